// File: doc/BRIEF.md
# Power Key Reset and Load-Switch Sequencer

This controller decides when a battery-to-load power switch conducts. A single power key (active low) has two jobs. While the switch is open, a long hold closes it. While the switch is closed, a longer hold forces a reset: the switch opens for a fixed pulse and then closes again by itself. A wake input closes the switch at once. An off request opens it, either after a long grace period that lets the load shut down cleanly or almost at once. A delay-select input, when low before the key goes down or before the off request rises, skips the long waits so that a production test can run quickly.

Every duration counts a one-millisecond tick and is set by a parameter in milliseconds. The reset hold time is scaled by a three-bit adjust code. All inputs pass through two-flop synchronisers before any edge is detected. When events coincide, they are resolved by a fixed priority: key first, then wake, then the off request. An event that loses arbitration is discarded. A discharge enable is driven as the exact complement of the switch enable.

Top module: `pwrkey_sequencer`

## Requirements
- R1: After reset, sw_en is 1 and dis_en is 0. The synchronisers start as key high, delay-select high, wake low, off low and adjust code 7.
- R2: dis_en is always the inverse of sw_en.
- R3: With the switch open and delay-select high at the key's falling edge, holding key_n low for T_ON_MS ticks closes the switch.
- R4: With the switch closed, holding key_n low for the scaled reset delay opens the switch for T_PULSE_MS ticks. The switch then closes again without any further input.
- R5: Releasing key_n before the reset delay expires clears the hold count and leaves the switch closed.
- R6: After a key action has fired, holding key_n low longer has no further effect. key_n must go high to re-arm the key.
- R7: If dly_sel is low when key_n falls, the key action fires on that edge. An open switch closes at once. A closed switch starts the reset pulse at once, and the pulse keeps its full T_PULSE_MS length.
- R8: A rising edge on wake closes an open switch within two ticks.
- R9: A rising edge on off_req with the switch closed starts a turn-off countdown. The switch opens after T_OFF_MS ticks if dly_sel was high at that edge, or after T_OFF_FAST_MS ticks if it was low. If off_req falls before OFF_QUAL_MS ticks have elapsed, the countdown is cancelled.
- R10: A key falling edge or a wake rising edge during the countdown aborts it, and the switch stays closed. off_req must fall and rise again to start a new countdown.
- R11: When events fall in the same cycle, key beats wake and wake beats off. A losing event is dropped and is not served later.
- R12: The adjust code scales T_RST_MS by these factors: 0 gives x0.5, 1 gives x0.75, 2 gives x1.25, 3 gives x1.5, 4 gives x1.75, 5 gives x2.0, and 6 or 7 give x1.0.
- R13: Timers advance only on cycles where tick_ms is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| key_n | input | 1 | Power key, active low, asynchronous |
| wake | input | 1 | Wake request, asynchronous |
| off_req | input | 1 | Off request, asynchronous |
| dly_sel | input | 1 | High selects normal delays; low selects the bypass |
| adj_code | input | 3 | Reset-delay multiplier select |
| sw_en | output | 1 | Load-switch enable |
| dis_en | output | 1 | Output-discharge enable |

## Verification
The key is exercised with three kinds of hold: holds that end before the threshold, holds that cross it, and holds that run well past a fired action. Each is tried with the switch open and with it closed, so the bench can tell the power-on, reset and re-arm paths apart. The off request is driven with long and short highs and with both delay-select settings, which separates the completed, fast and cancelled turn-offs. Same-cycle pairs of key, wake and off show which event wins arbitration. All adjust codes are tried, plus random codes with random release points, so the bench can check the multiplier table against its own expected delays.

// File: rtl/pks_pkg.sv
package pks_pkg;

  typedef enum logic [1:0] {
    PS_OFF      = 2'd0,
    PS_ON       = 2'd1,
    PS_PULSE    = 2'd2,
    PS_OFFWAIT  = 2'd3
  } pks_state_e;

  // Reset-delay multiplier in quarters, selected by the adjust code.
  function automatic logic [3:0] adj_quarters(input logic [2:0] code);
    logic [3:0] q;
    case (code)
      3'd0:    q = 4'd2;
      3'd1:    q = 4'd3;
      3'd2:    q = 4'd5;
      3'd3:    q = 4'd6;
      3'd4:    q = 4'd7;
      3'd5:    q = 4'd8;
      default: q = 4'd4;
    endcase
    return q;
  endfunction

  // Scaled reset delay in milliseconds.
  function automatic logic [31:0] scaled_ms(input logic [31:0] base, input logic [2:0] code);
    logic [35:0] prod;
    prod = {4'd0, base} * {32'd0, adj_quarters(code)};
    return prod[33:2];
  endfunction

endpackage

// File: rtl/pks_sync.sv
module pks_sync #(
  parameter int unsigned  W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pks_ms_timer.sv
module pks_ms_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cnt <= '0;
    else if (clr)                             cnt <= '0;
    else if (en && tick && (cnt != CNT_MAX))  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pks_prio_arb.sv
module pks_prio_arb #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] above;

  for (genvar i = 0; i < N; i++) begin : g_lvl
    if (i == 0) begin : g_top
      assign above[i] = 1'b0;
    end else begin : g_rest
      assign above[i] = above[i-1] | req[i-1];
    end
    assign gnt[i] = req[i] & ~above[i];
  end
endmodule

// File: rtl/pwrkey_sequencer.sv
module pwrkey_sequencer #(
  parameter int unsigned T_ON_MS       = 2300,
  parameter int unsigned T_RST_MS      = 7500,
  parameter int unsigned T_PULSE_MS    = 400,
  parameter int unsigned T_OFF_MS      = 7300,
  parameter int unsigned T_OFF_FAST_MS = 1,
  parameter int unsigned OFF_QUAL_MS   = 1,
  parameter int unsigned CNT_W         = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       key_n,
  input  logic       wake,
  input  logic       off_req,
  input  logic       dly_sel,
  input  logic [2:0] adj_code,
  output logic       sw_en,
  output logic       dis_en
);
  import pks_pkg::*;

  localparam int unsigned NEV = 3;  // 0 key, 1 wake, 2 off
  localparam logic [CNT_W-1:0] ON_LIM    = CNT_W'(T_ON_MS);
  localparam logic [CNT_W-1:0] PULSE_LIM = CNT_W'(T_PULSE_MS);
  localparam logic [CNT_W-1:0] OFF_LIM   = CNT_W'(T_OFF_MS);
  localparam logic [CNT_W-1:0] FAST_LIM  = CNT_W'(T_OFF_FAST_MS);
  localparam logic [CNT_W-1:0] QUAL_LIM  = CNT_W'(OFF_QUAL_MS);

  // ---------------- synchronisers ----------------
  logic [2:0] ev_raw, ev_s, ev_prev;
  logic [3:0] cfg_s;
  assign ev_raw = {off_req, wake, key_n};

  pks_sync #(.W(3), .RST_VAL(3'b001)) u_sync_ev (
    .clk(clk), .rst_n(rst_n), .d(ev_raw), .q(ev_s));

  pks_sync #(.W(4), .RST_VAL(4'b1111)) u_sync_cfg (
    .clk(clk), .rst_n(rst_n), .d({dly_sel, adj_code}), .q(cfg_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_prev <= 3'b001;
    else        ev_prev <= ev_s;
  end

  logic       key_s, off_s, dsel_s;
  logic [2:0] adj_s;
  logic       key_fall, wake_rise, off_rise;
  assign key_s     = ev_s[0];
  assign off_s     = ev_s[2];
  assign dsel_s    = cfg_s[3];
  assign adj_s     = cfg_s[2:0];
  assign key_fall  = ~ev_s[0] &  ev_prev[0];
  assign wake_rise =  ev_s[1] & ~ev_prev[1];
  assign off_rise  =  ev_s[2] & ~ev_prev[2];

  // ---------------- arbitration ----------------
  logic [NEV-1:0] arb_req, gnt;
  assign arb_req = {off_rise, wake_rise, key_fall};

  pks_prio_arb #(.N(NEV)) u_arb (.req(arb_req), .gnt(gnt));

  // ---------------- state and timers ----------------
  pks_state_e       st, st_nxt;
  logic             key_armed, key_fast_q, off_fast_q;
  logic [CNT_W-1:0] key_cnt, st_cnt;
  logic [CNT_W-1:0] key_lim, rst_lim, drain_lim;
  logic             key_clr, st_entry, st_timing;

  assign rst_lim   = CNT_W'(scaled_ms(32'(T_RST_MS), adj_s));
  assign key_lim   = (st == PS_OFF) ? ON_LIM : rst_lim;
  assign drain_lim = off_fast_q ? FAST_LIM : OFF_LIM;
  assign key_clr   = key_s | ~key_armed | key_fall;
  assign st_timing = (st == PS_PULSE) || (st == PS_OFFWAIT);
  assign st_entry  = (st_nxt != st);

  pks_ms_timer #(.CNT_W(CNT_W)) u_key_tmr (
    .clk(clk), .rst_n(rst_n), .clr(key_clr), .en(~key_clr),
    .tick(tick_ms), .cnt(key_cnt));

  pks_ms_timer #(.CNT_W(CNT_W)) u_st_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st_entry), .en(st_timing),
    .tick(tick_ms), .cnt(st_cnt));

  // Named internal events
  logic fast_now, key_fire, pulse_done, drain_done, drain_cancel, abort_hit;
  assign fast_now     = key_fall ? ~dsel_s : key_fast_q;
  assign key_fire     = key_armed & ~key_s & (st != PS_PULSE) &
                        (fast_now | (key_cnt >= key_lim));
  assign pulse_done   = (st == PS_PULSE) && (st_cnt >= PULSE_LIM);
  assign drain_cancel = (st == PS_OFFWAIT) && !off_s && (st_cnt < QUAL_LIM);
  assign drain_done   = (st == PS_OFFWAIT) && (st_cnt >= drain_lim);
  assign abort_hit    = (st == PS_OFFWAIT) && (gnt[0] || gnt[1]);

  always_comb begin
    st_nxt = st;
    unique case (st)
      PS_OFF: begin
        if (key_fire || gnt[1]) st_nxt = PS_ON;
      end
      PS_ON: begin
        if (key_fire)     st_nxt = PS_PULSE;
        else if (gnt[2])  st_nxt = PS_OFFWAIT;
      end
      PS_OFFWAIT: begin
        if (key_fire)          st_nxt = PS_PULSE;
        else if (abort_hit)    st_nxt = PS_ON;
        else if (drain_cancel) st_nxt = PS_ON;
        else if (drain_done)   st_nxt = PS_OFF;
      end
      PS_PULSE: begin
        if (pulse_done) st_nxt = PS_ON;
      end
      default: st_nxt = PS_ON;
    endcase
  end

  logic on_nxt;
  assign on_nxt = (st_nxt == PS_ON) || (st_nxt == PS_OFFWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= PS_ON;
      key_armed  <= 1'b1;
      key_fast_q <= 1'b0;
      off_fast_q <= 1'b0;
      sw_en      <= 1'b1;
      dis_en     <= 1'b0;
    end else begin
      st <= st_nxt;
      if (key_s)         key_armed <= 1'b1;
      else if (key_fire) key_armed <= 1'b0;
      if (key_fall)      key_fast_q <= ~dsel_s;
      else if (key_s)    key_fast_q <= 1'b0;
      if (st == PS_ON && st_nxt == PS_OFFWAIT) off_fast_q <= ~dsel_s;
      sw_en  <= on_nxt;
      dis_en <= ~on_nxt;
    end
  end

endmodule

// File: rtl/pks_checker.sv
module pks_checker (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sw_en,
  input logic                 dis_en,
  input pks_pkg::pks_state_e  st,
  input logic [2:0]           arb_req,
  input logic [2:0]           gnt,
  input logic                 key_fire
);
  import pks_pkg::*;

  AST_DISCHARGE_OPPOSES: assert property (@(posedge clk) disable iff (!rst_n)
    dis_en != sw_en); // R2

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R11

  AST_LOW_PRIO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_ON) && arb_req[2] && (arb_req[0] || arb_req[1]) |=> st != PS_OFFWAIT); // R11

  AST_PULSE_RETURNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_PULSE) |=> (st == PS_PULSE) || (st == PS_ON)); // R4

  AST_WAKE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_OFF) && gnt[1] |=> sw_en); // R8

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_OFF) && !key_fire && !gnt[1] |=> !sw_en); // R3

  AST_COUNTDOWN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_OFFWAIT) |-> sw_en); // R9

endmodule

bind pwrkey_sequencer pks_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .dis_en(dis_en), .st(st),
  .arb_req(arb_req), .gnt(gnt), .key_fire(key_fire));

// File: tb/pwrkey_sequencer_tb.sv
`timescale 1ns/1ps
module pwrkey_sequencer_tb;
  localparam int TP    = 4;   // clocks per tick
  localparam int BASE  = 40;
  localparam int T_ON  = 20;
  localparam int PULSE = 8;
  localparam int TOFF  = 30;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic key_n = 1'b1, wake = 1'b0, off_req = 1'b0, dsel = 1'b1;
  logic [2:0] adj = 3'd7;
  logic sw_en, dis_en;
  int n_chk = 0, n_fail = 0, tdiv = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= (tdiv == TP-1) ? 0 : tdiv + 1;
    tick <= (tdiv == TP-1);
  end

  pwrkey_sequencer #(.T_ON_MS(T_ON), .T_RST_MS(BASE), .T_PULSE_MS(PULSE),
    .T_OFF_MS(TOFF), .T_OFF_FAST_MS(1), .OFF_QUAL_MS(3), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick), .key_n(key_n), .wake(wake),
    .off_req(off_req), .dly_sel(dsel), .adj_code(adj), .sw_en(sw_en), .dis_en(dis_en));

  function automatic int exp_delay(input int code);
    case (code)
      0: return BASE / 2;
      1: return (BASE * 3) / 4;
      2: return BASE + BASE / 4;
      3: return BASE + BASE / 2;
      4: return 2 * BASE - BASE / 4;
      5: return 2 * BASE;
      default: return BASE;
    endcase
  endfunction

  task automatic wt(input int n);
    repeat (n * TP) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sw_en, 1'b1, "R1 sw_en after reset");
    chk(dis_en, 1'b0, "R1 dis_en after reset");

    // R4 / R6 / R13: long hold with switch closed, default multiplier
    key_n = 1'b0;
    wt(BASE - 3); chk(sw_en, 1'b1, "R4 before reset delay");
    wt(6);        chk(sw_en, 1'b0, "R4 pulse open");
                  chk(dis_en, 1'b1, "R2 discharge during pulse");
    wt(12);       chk(sw_en, 1'b1, "R4 closed after pulse");
    wt(BASE + 5); chk(sw_en, 1'b1, "R6 held key no second reset");
    key_n = 1'b1; wt(3);

    // R5: early release clears count
    key_n = 1'b0; wt(BASE - 5); key_n = 1'b1; wt(3);
    chk(sw_en, 1'b1, "R5 early release");
    key_n = 1'b0; wt(BASE - 5);
    chk(sw_en, 1'b1, "R5 count restarted");
    key_n = 1'b1; wt(3);

    // R9: long turn-off
    off_req = 1'b1;
    wt(TOFF - 4); chk(sw_en, 1'b1, "R9 countdown running");
    wt(8);        chk(sw_en, 1'b0, "R9 opened after countdown");
                  chk(dis_en, 1'b1, "R2 discharge when open");

    // R3 / R6: power-on by hold
    key_n = 1'b0;
    wt(T_ON - 3); chk(sw_en, 1'b0, "R3 still open");
    wt(6);        chk(sw_en, 1'b1, "R3 closed by hold");
    wt(BASE + 5); chk(sw_en, 1'b1, "R6 no reset after power-on");
    key_n = 1'b1; off_req = 1'b0; wt(3);

    // R9 fast turn-off
    dsel = 1'b0; wt(2);
    off_req = 1'b1; wt(4);
    chk(sw_en, 1'b0, "R9 fast turn-off");
    off_req = 1'b0; wt(2);

    // R7 fast power-on and fast reset
    key_n = 1'b0; wt(3);
    chk(sw_en, 1'b1, "R7 immediate close");
    wt(10); chk(sw_en, 1'b1, "R7 no reset while held");
    key_n = 1'b1; wt(3);
    key_n = 1'b0; wt(3);
    chk(sw_en, 1'b0, "R7 immediate reset pulse");
    wt(PULSE - 5); chk(sw_en, 1'b0, "R7 pulse keeps length");
    wt(9);  chk(sw_en, 1'b1, "R7 closed after pulse");
    key_n = 1'b1; dsel = 1'b1; wt(3);

    // R9 cancel on short off request
    off_req = 1'b1; wt(1); off_req = 1'b0;
    wt(TOFF + 10); chk(sw_en, 1'b1, "R9 short request cancelled");

    // R10 abort by wake, then re-arm
    off_req = 1'b1; wt(10);
    wake = 1'b1; wt(2);
    chk(sw_en, 1'b1, "R10 abort keeps closed");
    wt(TOFF); chk(sw_en, 1'b1, "R10 no restart while off high");
    wake = 1'b0; off_req = 1'b0; wt(2);
    off_req = 1'b1; wt(TOFF + 4);
    chk(sw_en, 1'b0, "R10 re-armed turn-off");
    off_req = 1'b0; wt(2);

    // R8 wake closes
    wake = 1'b1; wt(2);
    chk(sw_en, 1'b1, "R8 wake closes");
    wake = 1'b0; wt(2);

    // R10 abort by key
    off_req = 1'b1; wt(10);
    key_n = 1'b0; wt(2); key_n = 1'b1;
    wt(TOFF); chk(sw_en, 1'b1, "R10 key abort");
    off_req = 1'b0; wt(2);
    off_req = 1'b1; wt(TOFF + 4);
    chk(sw_en, 1'b0, "R10 open for priority test");
    off_req = 1'b0; wt(2);

    // R11 key beats wake with switch open
    key_n = 1'b0; wake = 1'b1; wt(8);
    chk(sw_en, 1'b0, "R11 wake dropped behind key");
    key_n = 1'b1; wt(3);
    chk(sw_en, 1'b0, "R11 wake not served later");
    wake = 1'b0; wt(2); wake = 1'b1; wt(2);
    chk(sw_en, 1'b1, "R11 repeated wake served");
    wake = 1'b0; wt(2);

    // R11 key beats off, wake beats off, switch closed
    key_n = 1'b0; off_req = 1'b1; wt(2); key_n = 1'b1;
    wt(TOFF + 10); chk(sw_en, 1'b1, "R11 off dropped behind key");
    off_req = 1'b0; wt(2);
    wake = 1'b1; off_req = 1'b1;
    wt(TOFF + 10); chk(sw_en, 1'b1, "R11 off dropped behind wake");
    wake = 1'b0; off_req = 1'b0; wt(2);

    // R12 every adjust code, directed
    for (int c = 0; c < 8; c++) begin
      int d;
      adj = 3'(c); wt(2);
      d = exp_delay(c);
      key_n = 1'b0;
      wt(d - 3); chk(sw_en, 1'b1, $sformatf("R12 code %0d before", c));
      wt(6);     chk(sw_en, 1'b0, $sformatf("R12 code %0d fired", c));
      wt(12);    chk(sw_en, 1'b1, $sformatf("R12 code %0d restored", c));
      key_n = 1'b1; wt(3);
    end

    // R12 / R5 random codes and hold lengths
    for (int i = 0; i < 10; i++) begin
      int c, d, h;
      c = int'($urandom % 8);
      adj = 3'(c); wt(2);
      d = exp_delay(c);
      if (($urandom % 3) == 0) begin
        h = 3 + int'($urandom % 32'(d - 6));
        key_n = 1'b0; wt(h); key_n = 1'b1; wt(3);
        chk(sw_en, 1'b1, $sformatf("R5 random release code %0d hold %0d", c, h));
      end else begin
        key_n = 1'b0;
        wt(d - 3); chk(sw_en, 1'b1, $sformatf("R12 random code %0d before", c));
        wt(6);     chk(sw_en, 1'b0, $sformatf("R12 random code %0d fired", c));
        wt(12);    chk(sw_en, 1'b1, $sformatf("R12 random code %0d restored", c));
        key_n = 1'b1; wt(3);
      end
    end

    summary();
  end
endmodule